// File: doc/BRIEF.md
# Multiplexed-Address Burst Write Target

This block is the slave side of a clocked host bus where address and data share one set of wires. The host first pulses an address-latch input while chip select is low, which puts the starting word address into the block. One clock later it pulls the data strobe low for exactly one clock, which opens a sequential burst. From then on the block takes one 16-bit word per clock from the shared bus, tags it with an address that counts up from the latched start, and ends the burst on the word that the host marks with the active-low last-word input.

Each accepted word becomes one entry of an internal command FIFO. An entry holds the word address, the data and the memory/register space bit captured with the address. Downstream logic drains the FIFO through a valid/ready port. When the FIFO is full, the block drives its active-low stop output, drops ready and holds the burst in place until space frees up. A burst that starts with the wrong word enables, or with the direction input showing a read, takes no data and raises a one-cycle protocol error pulse.

Top module: `mux_burst_wr_target`

## Requirements
- R1: After a synchronous reset, `host_rdy_n` and `host_stop_n` are 1, `proto_err` and `cmd_valid` are 0, and the control logic is idle.
- R2: In idle, a clock edge with `host_sel_n`=0 and `host_alat`=1 captures `host_ad` as the starting word address and `host_space` as the space bit of the burst. Later changes of `host_space` do not alter the entries of that burst.
- R3: The burst starts only if, at the edge right after the address capture, `host_sel_n`=0 and `host_dstb_n`=0. `host_rdy_n` goes low at that edge, and the first word is taken from `host_ad` at the next edge. If the strobe is missing at that edge, the block returns to idle and takes no word.
- R4: Each accepted word is written with the latched address plus the number of words accepted before it in the burst, modulo 2^BUS_W, so a start of 0xFFFF gives 0xFFFF then 0x0000.
- R5: A word taken with `host_last_n`=0 is the final word of the burst. After that edge `host_rdy_n` is 1 and no further word is taken until a new address capture.
- R6: If `host_sel_n` is 1 at an edge during a burst, the word on the bus is not taken, the burst ends and `host_rdy_n` is 1 after that edge.
- R7: A burst start with `host_wen` other than 2'b11, or with `host_rd_wr_n`=1 (1 means read, 0 means write), raises `proto_err` for exactly one cycle after the strobe edge. No burst opens and no entry is written.
- R8: `host_stop_n` is 0 exactly while the FIFO holds FIFO_DEPTH entries. While it is 0 during a burst, `host_rdy_n` is 1, no word is taken and the address does not advance.
- R9: Entries leave on `cmd_valid`/`cmd_addr`/`cmd_data`/`cmd_space` in acceptance order. An entry is removed at an edge where `cmd_valid` and `cmd_ready` are both 1, and `cmd_valid` is 0 when the FIFO is empty.
- R10: In idle, `host_alat` is ignored while `host_sel_n` is 1. A data strobe that follows does not start a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| host_sel_n | input | 1 | Chip select, active low |
| host_alat | input | 1 | Address-latch pulse, active high |
| host_dstb_n | input | 1 | Burst-start data strobe, active low |
| host_last_n | input | 1 | Final-word marker, active low |
| host_rd_wr_n | input | 1 | Direction: 1 read, 0 write |
| host_space | input | 1 | Memory/register space bit, sampled with the address |
| host_wen | input | 2 | Byte-lane enables, 2'b11 for 16-bit words |
| host_ad | input | BUS_W | Shared address/data bus |
| host_rdy_n | output | 1 | Word-ready, active low |
| host_stop_n | output | 1 | Backpressure, active low, FIFO full |
| proto_err | output | 1 | One-cycle protocol error pulse |
| cmd_valid | output | 1 | FIFO head entry is valid |
| cmd_ready | input | 1 | Consumer takes the head entry |
| cmd_space | output | 1 | Space bit of the head entry |
| cmd_addr | output | BUS_W | Word address of the head entry |
| cmd_data | output | BUS_W | Data of the head entry |

## Verification
The bench builds the block with BUS_W=16 and FIFO_DEPTH=4. The shallow FIFO means a seven-word burst with the consumer held off fills it in four words. That brings the stall path within reach: stop low, ready high, the address held, then resuming after single pops. The 16-bit bus lets a start address of 0xFFFF show the address wrap in a three-word burst.

// File: rtl/mbw_pkg.sv
package mbw_pkg;

  typedef enum logic [1:0] {
    FE_IDLE    = 2'd0,
    FE_LATCHED = 2'd1,
    FE_BURST   = 2'd2
  } fe_state_e;

  localparam logic [1:0] WEN_WORD = 2'b11;

endpackage

// File: rtl/mbw_frontend.sv
module mbw_frontend
  import mbw_pkg::*;
#(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             alat,
  input  logic             dstb_n,
  input  logic             last_n,
  input  logic             rd_wr_n,
  input  logic             space_in,
  input  logic [1:0]       wen,
  input  logic [BUS_W-1:0] ad,
  input  logic             fifo_full,
  output logic             rdy_n,
  output logic             err,
  output logic             push,
  output logic             push_space,
  output logic [BUS_W-1:0] push_addr,
  output logic [BUS_W-1:0] push_data
);

  fe_state_e        state_q;
  logic [BUS_W-1:0] addr_q;
  logic             space_q;
  logic             err_q;
  logic             start_ok;
  logic             take;

  assign start_ok = (wen == WEN_WORD) && !rd_wr_n;
  assign take     = (state_q == FE_BURST) && !sel_n && !fifo_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FE_IDLE;
      addr_q  <= '0;
      space_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state_q)
        FE_IDLE: begin
          if (!sel_n && alat) begin
            addr_q  <= ad;
            space_q <= space_in;
            state_q <= FE_LATCHED;
          end
        end
        FE_LATCHED: begin
          if (!sel_n && !dstb_n && start_ok) begin
            state_q <= FE_BURST;
          end else begin
            err_q   <= !sel_n && !dstb_n;
            state_q <= FE_IDLE;
          end
        end
        FE_BURST: begin
          if (sel_n) begin
            state_q <= FE_IDLE;
          end else if (take) begin
            addr_q <= addr_q + 1'b1;
            if (!last_n) state_q <= FE_IDLE;
          end
        end
        default: state_q <= FE_IDLE;
      endcase
    end
  end

  assign rdy_n      = (state_q != FE_BURST) || fifo_full;
  assign err        = err_q;
  assign push       = take;
  assign push_space = space_q;
  assign push_addr  = addr_q;
  assign push_data  = ad;

  // R4: the address moves by one after every accepted word
  a_r4_addr_step: assert property (@(posedge clk) disable iff (rst)
    push |=> (addr_q == $past(addr_q) + 1'b1));

  // R8: the address holds while the FIFO blocks the burst
  a_r8_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (state_q == FE_BURST && !sel_n && fifo_full) |=> $stable(addr_q));

  // R5: the final word closes the burst
  a_r5_last_closes: assert property (@(posedge clk) disable iff (rst)
    (push && !last_n) |=> (rdy_n && state_q == FE_IDLE));

  // R6: deselect aborts the burst
  a_r6_abort: assert property (@(posedge clk) disable iff (rst)
    (state_q == FE_BURST && sel_n) |=> (state_q == FE_IDLE));

  // R7: bad start flags an error and opens no burst
  a_r7_bad_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == FE_LATCHED && !sel_n && !dstb_n && (wen != WEN_WORD || rd_wr_n))
      |=> (err && state_q == FE_IDLE));

  // R7: the error flag lasts one cycle
  a_r7_err_pulse: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

endmodule

// File: rtl/mbw_cmd_fifo.sv
module mbw_cmd_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_ready,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q;
  logic [PTR_W-1:0] rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             rd_en;

  assign rd_valid = (count_q != '0);
  assign rd_en    = rd_valid && rd_ready;
  assign full     = (count_q == FULL_CNT);
  assign rd_data  = store[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_ptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= (wr_ptr_q == LAST_SLOT) ? '0 : wr_ptr_q + 1'b1;
      if (rd_en) rd_ptr_q <= (rd_ptr_q == LAST_SLOT) ? '0 : rd_ptr_q + 1'b1;
      unique case ({wr_en, rd_en})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  // R8: no write lands on a full FIFO
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);

  // R9: a pop of the only entry leaves the FIFO empty
  a_r9_drain_last: assert property (@(posedge clk) disable iff (rst)
    (count_q == 1 && rd_en && !wr_en) |=> !rd_valid);

  // R9: a write to an empty FIFO shows valid next cycle
  a_r9_fill_first: assert property (@(posedge clk) disable iff (rst)
    (!rd_valid && wr_en) |=> rd_valid);

endmodule

// File: rtl/mux_burst_wr_target.sv
module mux_burst_wr_target #(
  parameter int BUS_W      = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_sel_n,
  input  logic             host_alat,
  input  logic             host_dstb_n,
  input  logic             host_last_n,
  input  logic             host_rd_wr_n,
  input  logic             host_space,
  input  logic [1:0]       host_wen,
  input  logic [BUS_W-1:0] host_ad,
  output logic             host_rdy_n,
  output logic             host_stop_n,
  output logic             proto_err,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic             cmd_space,
  output logic [BUS_W-1:0] cmd_addr,
  output logic [BUS_W-1:0] cmd_data
);

  localparam int ENTRY_W = 1 + 2 * BUS_W;

  logic             fifo_full;
  logic             push;
  logic             push_space;
  logic [BUS_W-1:0] push_addr;
  logic [BUS_W-1:0] push_data;
  logic [ENTRY_W-1:0] head;

  mbw_frontend #(.BUS_W(BUS_W)) u_frontend (
    .clk        (clk),
    .rst        (rst),
    .sel_n      (host_sel_n),
    .alat       (host_alat),
    .dstb_n     (host_dstb_n),
    .last_n     (host_last_n),
    .rd_wr_n    (host_rd_wr_n),
    .space_in   (host_space),
    .wen        (host_wen),
    .ad         (host_ad),
    .fifo_full  (fifo_full),
    .rdy_n      (host_rdy_n),
    .err        (proto_err),
    .push       (push),
    .push_space (push_space),
    .push_addr  (push_addr),
    .push_data  (push_data)
  );

  mbw_cmd_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (push),
    .wr_data  ({push_space, push_addr, push_data}),
    .rd_ready (cmd_ready),
    .rd_valid (cmd_valid),
    .rd_data  (head),
    .full     (fifo_full)
  );

  assign host_stop_n = !fifo_full;
  assign cmd_space   = head[ENTRY_W-1];
  assign cmd_addr    = head[2*BUS_W-1:BUS_W];
  assign cmd_data    = head[BUS_W-1:0];

  // R8: ready is never shown while stop is shown
  a_r8_stop_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    !host_stop_n |-> host_rdy_n);

  // R1: outputs are inactive in the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (host_rdy_n && host_stop_n && !proto_err && !cmd_valid));

endmodule

// File: tb/test_mux_burst_wr_target.sv
module test_mux_burst_wr_target;

  localparam int BW    = 16;
  localparam int DEPTH = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_n = 1'b1, alat = 1'b0, dstb_n = 1'b1, last_n = 1'b1;
  logic          rdwr = 1'b0, space = 1'b0;
  logic [1:0]    wen = 2'b11;
  logic [BW-1:0] ad = '0;
  logic          rdy_n, stop_n, perr, cvalid, cspace;
  logic          cready = 1'b0;
  logic [BW-1:0] caddr, cdata;

  int total = 0;
  int bad   = 0;
  logic [BW-1:0] exp_addr [64];
  logic [BW-1:0] exp_data [64];
  logic          exp_space[64];
  int wr_idx = 0;
  int rd_idx = 0;

  always #10 clk = ~clk;

  mux_burst_wr_target #(.BUS_W(BW), .FIFO_DEPTH(DEPTH)) i_mux_burst_wr_target (
    .clk(clk), .rst(rst),
    .host_sel_n(sel_n), .host_alat(alat), .host_dstb_n(dstb_n),
    .host_last_n(last_n), .host_rd_wr_n(rdwr), .host_space(space),
    .host_wen(wen), .host_ad(ad),
    .host_rdy_n(rdy_n), .host_stop_n(stop_n), .proto_err(perr),
    .cmd_valid(cvalid), .cmd_ready(cready), .cmd_space(cspace),
    .cmd_addr(caddr), .cmd_data(cdata)
  );

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic chk_head(input string tag);
    chk(cvalid == 1'b1, {tag, " R9 valid"}, 32'(cvalid), 1);
    chk(caddr == exp_addr[rd_idx], {tag, " R4 addr"}, 32'(caddr), 32'(exp_addr[rd_idx]));
    chk(cdata == exp_data[rd_idx], {tag, " R9 data"}, 32'(cdata), 32'(exp_data[rd_idx]));
    chk(cspace == exp_space[rd_idx], {tag, " R2 space"}, 32'(cspace), 32'(exp_space[rd_idx]));
  endtask

  task automatic drain(input string tag);
    @(negedge clk);
    cready = 1'b1;
    while (rd_idx < wr_idx) begin
      chk_head(tag);
      @(negedge clk);
      rd_idx++;
    end
    cready = 1'b0;
    chk(cvalid == 1'b0, {tag, " R9 empty"}, 32'(cvalid), 0);
  endtask

  task automatic open_burst(input logic [BW-1:0] a, input bit sp);
    @(negedge clk);
    sel_n = 1'b0; alat = 1'b1; ad = a; space = sp; rdwr = 1'b0; wen = 2'b11;
    @(negedge clk);
    alat = 1'b0; dstb_n = 1'b0; space = ~sp; ad = 16'h5A5A;
    @(negedge clk);
    dstb_n = 1'b1;
  endtask

  task automatic run_burst(input string tag, input logic [BW-1:0] a, input int n,
                           input logic [BW-1:0] db, input bit sp);
    int i = 0;
    int stall = 0;
    open_burst(a, sp);
    if (stop_n) chk(rdy_n == 1'b0, {tag, " R3 ready after strobe"}, 32'(rdy_n), 0);
    while (i < n) begin
      bit acc;
      bit popped;
      ad = db + BW'(i);
      last_n = (i == n - 1) ? 1'b0 : 1'b1;
      acc = (rdy_n == 1'b0);
      popped = 1'b0;
      if (!acc) begin
        chk(stop_n == 1'b0, {tag, " R8 stop while stalled"}, 32'(stop_n), 0);
        stall++;
        if (stall == 3) begin
          cready = 1'b1;
          chk_head({tag, " stall pop"});
          popped = 1'b1;
          stall = 0;
        end
      end
      @(negedge clk);
      cready = 1'b0;
      if (popped) rd_idx++;
      if (acc) begin
        exp_addr[wr_idx]  = a + BW'(i);
        exp_data[wr_idx]  = db + BW'(i);
        exp_space[wr_idx] = sp;
        wr_idx++;
        i++;
      end
    end
    chk(rdy_n == 1'b1, {tag, " R5 ready high after last"}, 32'(rdy_n), 1);
    sel_n = 1'b1; last_n = 1'b1;
  endtask

  task automatic t_reset;
    chk(rdy_n == 1'b1, "R1 rdy_n", 32'(rdy_n), 1);
    chk(stop_n == 1'b1, "R1 stop_n", 32'(stop_n), 1);
    chk(perr == 1'b0, "R1 proto_err", 32'(perr), 0);
    chk(cvalid == 1'b0, "R1 cmd_valid", 32'(cvalid), 0);
  endtask

  task automatic t_basic;
    run_burst("basic", 16'h0100, 4, 16'hA000, 1'b0);
    drain("basic");
  endtask

  task automatic t_single;
    run_burst("single", 16'h0042, 1, 16'hBEEF, 1'b1);
    drain("single");
  endtask

  task automatic t_wrap;
    run_burst("wrap", 16'hFFFF, 3, 16'h1230, 1'b1);
    drain("wrap");
  endtask

  task automatic t_stall;
    run_burst("stall", 16'h2000, 7, 16'hC000, 1'b0);
    chk(stop_n == 1'b1 || wr_idx - rd_idx == DEPTH, "R8 stop matches full",
        32'(stop_n), 1);
    drain("stall");
    chk(stop_n == 1'b1, "R8 stop released", 32'(stop_n), 1);
  endtask

  task automatic t_abort;
    open_burst(16'h0300, 1'b0);
    for (int k = 0; k < 2; k++) begin
      ad = 16'hD000 + BW'(k);
      last_n = 1'b1;
      @(negedge clk);
      exp_addr[wr_idx] = 16'h0300 + BW'(k);
      exp_data[wr_idx] = 16'hD000 + BW'(k);
      exp_space[wr_idx] = 1'b0;
      wr_idx++;
    end
    sel_n = 1'b1; ad = 16'hDEAD;
    @(negedge clk);
    chk(rdy_n == 1'b1, "R6 ready high after abort", 32'(rdy_n), 1);
    sel_n = 1'b0; ad = 16'hDEAF;
    @(negedge clk);
    chk(rdy_n == 1'b1, "R6 no resume", 32'(rdy_n), 1);
    sel_n = 1'b1;
    drain("abort R6");
  endtask

  task automatic t_err(input string tag, input logic [1:0] w, input logic rw);
    @(negedge clk);
    sel_n = 1'b0; alat = 1'b1; ad = 16'h0400; rdwr = 1'b0; wen = 2'b11;
    @(negedge clk);
    alat = 1'b0; dstb_n = 1'b0; wen = w; rdwr = rw;
    @(negedge clk);
    chk(perr == 1'b1, {tag, " R7 error pulse"}, 32'(perr), 1);
    chk(rdy_n == 1'b1, {tag, " R7 no ready"}, 32'(rdy_n), 1);
    dstb_n = 1'b1; ad = 16'h7777; last_n = 1'b0;
    @(negedge clk);
    chk(perr == 1'b0, {tag, " R7 pulse one cycle"}, 32'(perr), 0);
    chk(cvalid == 1'b0, {tag, " R7 nothing written"}, 32'(cvalid), 0);
    sel_n = 1'b1; last_n = 1'b1; wen = 2'b11; rdwr = 1'b0;
  endtask

  task automatic t_no_strobe;
    @(negedge clk);
    sel_n = 1'b0; alat = 1'b1; ad = 16'h0500;
    @(negedge clk);
    alat = 1'b0; dstb_n = 1'b1;
    @(negedge clk);
    dstb_n = 1'b0; ad = 16'h1111;
    @(negedge clk);
    dstb_n = 1'b1;
    chk(rdy_n == 1'b1, "R3 late strobe ignored", 32'(rdy_n), 1);
    @(negedge clk);
    chk(cvalid == 1'b0, "R3 no word without strobe", 32'(cvalid), 0);
    sel_n = 1'b1;
  endtask

  task automatic t_latch_deselected;
    @(negedge clk);
    sel_n = 1'b1; alat = 1'b1; ad = 16'h0600;
    @(negedge clk);
    alat = 1'b0; sel_n = 1'b0; dstb_n = 1'b0;
    @(negedge clk);
    dstb_n = 1'b1; ad = 16'h2222;
    chk(rdy_n == 1'b1, "R10 latch ignored when deselected", 32'(rdy_n), 1);
    @(negedge clk);
    chk(cvalid == 1'b0, "R10 no entry", 32'(cvalid), 0);
    sel_n = 1'b1;
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_single();
    t_wrap();
    t_stall();
    t_abort();
    t_err("wen", 2'b01, 1'b0);
    t_err("dir", 2'b11, 1'b1);
    t_no_strobe();
    t_latch_deselected();
    t_basic();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule